// File: doc/BRIEF.md
# Dual-Channel Down-Counting Timer Bank

This block is a register-mapped timer peripheral with two independent down-counters. Each channel keeps a control register, an interval register that supplies the reload value, and a live count register. A shared interrupt-enable register and a status register gate one interrupt line. Status bits are cleared by writing a one to them. Counting is paced by a tick-enable input that comes from the source oscillator. A per-channel prescaler divides that tick by a power of two.

Software starts a channel with a single control write that sets both the enable bit and the reload bit. Each channel then either reloads itself on every expiry (periodic mode) or halts after its first expiry (one-shot mode). Stopping a channel is not immediate. After enable is cleared, the counter keeps stepping for two more source ticks and then holds. If the interval is all ones, the channel becomes a free-running 32-bit down-counter, and inverting its count gives a rising timestamp. Register access is a single-cycle port: a write takes effect on the clock edge, and read data is registered one cycle after the address.

Top module: `tmr_bank`

## Requirements
- R1: While the synchronous active-high `rst` is high at a clock edge, every register is cleared: counts, intervals, controls, status and enables all become 0. After that edge `bus_rdata_o` and `irq_o` read 0.
- R2: The register map is as follows. Interrupt enable is at 0x00 and interrupt status at 0x04. Channel n has control at 0x10+0x10*n, interval at 0x14+0x10*n and count at 0x18+0x10*n. Any other address reads 0. `bus_rdata_o` shows, one clock after the address is presented, the register contents as they were before that edge.
- R3: The control byte is laid out as follows: bit 0 enable, bit 1 reload, bits 3:2 clock-source tag, bits 6:4 prescaler code, bit 7 one-shot. A control write with both enable and reload set copies the interval into the count and starts the channel. The reload bit always reads back as 0.
- R4: A running channel decrements its count by one on each prescaled step. A step from 1 to 0 sets status bit n.
- R5: In periodic mode (bit 7 = 0), the step that leaves 1 reloads the interval, and a step taken at 0 also reloads it.
- R6: In one-shot mode (bit 7 = 1), the expiry leaves the count at 0, clears the enable bit and halts the channel.
- R7: With prescaler code p, the channel steps once every 2^p cycles in which `tick_i` is high (p from 0 to 7). Cycles with `tick_i` low never advance a channel.
- R8: If a control write clears enable on a running channel, the channel keeps stepping on the next two `tick_i` cycles and then holds its count. A later write with enable set and reload clear resumes counting from the held value.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An expiry in the same cycle as the clearing write wins, so the bit stays set.
- R10: `irq_o` is registered. It equals the OR over channels of (status AND enable) as they stood one cycle earlier.
- R11: With an interval of all ones in periodic mode, the count runs freely downward, so its bitwise inverse rises.
- R12: Writes to a count register are ignored. The clock-source tag is stored and read back but has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-clock enable pulse from the source oscillator |
| bus_addr_i | input | AW (8) | Register byte address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | CW (32) | Write data |
| bus_rdata_o | output | CW (32) | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Several properties are checked on every cycle by assertions. The interrupt line must follow the gated status with one cycle of lag. An expiry pulse must always set its status bit. A status bit may rise only through an expiry. A halted channel's count must not move unless its control register is written. A running count moves by at most one per cycle.

The bench's scenarios are needed for the rest, because these depend on a sequence of writes and ticks. That covers the exact two-tick stop window, prescaler spacing, one-shot self-disable, write-one-to-clear races, read latency and free-running behaviour. A behavioural reference model compares read data and the interrupt on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W     = 8;
  localparam int PRESC_W    = 3;
  localparam int PCNT_W     = (1 << PRESC_W) - 1;
  localparam int STOP_TICKS = 2;
  localparam int STOP_W     = $clog2(STOP_TICKS + 1);

  localparam int OFS_IEN    = 'h00;
  localparam int OFS_IST    = 'h04;
  localparam int CH_BASE    = 'h10;
  localparam int CH_STRIDE  = 'h10;
  localparam int OFS_CTRL   = 'h0;
  localparam int OFS_INTV   = 'h4;
  localparam int OFS_CNT    = 'h8;

  typedef struct packed {
    logic                oneshot;
    logic [PRESC_W-1:0]  presc;
    logic [1:0]          src;
    logic                reload;
    logic                en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               clr_i,
  input  logic [PRESC_W-1:0] code_i,
  output logic               step_o
);
  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] lim;

  // terminal value 2^code - 1
  always_comb lim = ~({PCNT_W{1'b1}} << code_i);

  assign step_o = tick_i && run_i && (pcnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pcnt_q <= '0;
    end else if (tick_i && run_i) begin
      pcnt_q <= step_o ? '0 : pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          ctrl_we_i,
  input  logic          intv_we_i,
  input  logic [CW-1:0] wdata_i,
  output tmr_ctrl_t     ctrl_o,
  output logic [CW-1:0] intv_o,
  output logic [CW-1:0] cnt_o,
  output logic          run_o,
  output logic          expire_o
);
  tmr_ctrl_t         ctrl_q;
  tmr_ctrl_t         wr_ctrl;
  logic [CW-1:0]     intv_q;
  logic [CW-1:0]     cnt_q;
  logic              run_q;
  logic [STOP_W-1:0] stop_q;
  logic              step;
  logic              load;

  assign wr_ctrl  = tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign load     = ctrl_we_i && wr_ctrl.en && wr_ctrl.reload;
  assign expire_o = step && (cnt_q == CW'(1));

  tmr_prescale u_presc (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .run_i  (run_q),
    .clr_i  (load),
    .code_i (ctrl_q.presc),
    .step_o (step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      intv_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      stop_q <= '0;
    end else begin
      // pending stop drains on source ticks
      if (tick_i && stop_q != '0) begin
        stop_q <= stop_q - 1'b1;
        if (stop_q == STOP_W'(1)) run_q <= 1'b0;
      end
      if (step) begin
        if (cnt_q == CW'(1)) begin
          if (ctrl_q.oneshot) begin
            cnt_q     <= '0;
            run_q     <= 1'b0;
            ctrl_q.en <= 1'b0;
            stop_q    <= '0;
          end else begin
            cnt_q <= intv_q;
          end
        end else if (cnt_q == '0) begin
          if (!ctrl_q.oneshot) cnt_q <= intv_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (intv_we_i) intv_q <= wdata_i;
      if (ctrl_we_i) begin
        ctrl_q        <= wr_ctrl;
        ctrl_q.reload <= 1'b0;
        if (load) begin
          cnt_q  <= intv_q;
          run_q  <= 1'b1;
          stop_q <= '0;
        end else if (wr_ctrl.en) begin
          run_q  <= 1'b1;
          stop_q <= '0;
        end else if (run_q && stop_q == '0) begin
          stop_q <= STOP_W'(STOP_TICKS);
        end
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign intv_o = intv_q;
  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_we_i,
  input  logic [CW-1:0] bus_wdata_i,
  output logic [CW-1:0] bus_rdata_o,
  output logic          irq_o
);
  tmr_ctrl_t                ctrl_v [NCH];
  logic [NCH-1:0][CW-1:0]   intv_v;
  logic [NCH-1:0][CW-1:0]   cnt_v;
  logic [NCH-1:0]           run_v;
  logic [NCH-1:0]           expire_v;
  logic [NCH-1:0]           wr_ctrl_v;
  logic [NCH-1:0]           wr_intv_v;
  logic [NCH-1:0]           ien_q;
  logic [NCH-1:0]           ist_q;
  logic [CW-1:0]            rdata_q;
  logic [CW-1:0]            rd_mux;
  logic                     irq_q;
  logic                     wr_ien;
  logic                     wr_ist;

  assign wr_ien = bus_we_i && (bus_addr_i == AW'(OFS_IEN));
  assign wr_ist = bus_we_i && (bus_addr_i == AW'(OFS_IST));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int BASE = CH_BASE + g * CH_STRIDE;
    assign wr_ctrl_v[g] = bus_we_i && (bus_addr_i == AW'(BASE + OFS_CTRL));
    assign wr_intv_v[g] = bus_we_i && (bus_addr_i == AW'(BASE + OFS_INTV));

    tmr_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .tick_i    (tick_i),
      .ctrl_we_i (wr_ctrl_v[g]),
      .intv_we_i (wr_intv_v[g]),
      .wdata_i   (bus_wdata_i),
      .ctrl_o    (ctrl_v[g]),
      .intv_o    (intv_v[g]),
      .cnt_o     (cnt_v[g]),
      .run_o     (run_v[g]),
      .expire_o  (expire_v[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == AW'(OFS_IEN)) rd_mux = CW'(ien_q);
    if (bus_addr_i == AW'(OFS_IST)) rd_mux = CW'(ist_q);
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr_i == AW'(CH_BASE + c * CH_STRIDE + OFS_CTRL))
        rd_mux = {{(CW-CTRL_W){1'b0}}, ctrl_v[c]};
      if (bus_addr_i == AW'(CH_BASE + c * CH_STRIDE + OFS_INTV))
        rd_mux = intv_v[c];
      if (bus_addr_i == AW'(CH_BASE + c * CH_STRIDE + OFS_CNT))
        rd_mux = cnt_v[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= '0;
      ist_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_ist) ist_q <= (ist_q & ~bus_wdata_i[NCH-1:0]) | expire_v;
      else        ist_q <= ist_q | expire_v;
      if (wr_ien) ien_q <= bus_wdata_i[NCH-1:0];
      irq_q   <= |(ist_q & ien_q);
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NCH = 2,
  parameter int CW  = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   irq_o,
  input logic [NCH-1:0]         ist_q,
  input logic [NCH-1:0]         ien_q,
  input logic [NCH-1:0]         run_v,
  input logic [NCH-1:0]         expire_v,
  input logic [NCH-1:0]         wr_ctrl_v,
  input logic [NCH-1:0][CW-1:0] cnt_v
);
  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(ist_q & ien_q))));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r4_expiry_sets_status: assert property (@(posedge clk) disable iff (rst)
      expire_v[i] |=> ist_q[i]);

    a_r9_status_rises_only_on_expiry: assert property (@(posedge clk) disable iff (rst)
      (!ist_q[i] && !expire_v[i]) |=> !ist_q[i]);

    a_r8_halted_count_holds: assert property (@(posedge clk) disable iff (rst)
      (!run_v[i] && !wr_ctrl_v[i]) |=> $stable(cnt_v[i]));

    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
      (run_v[i] && cnt_v[i] > CW'(1) && !wr_ctrl_v[i]) |=>
        (cnt_v[i] == $past(cnt_v[i]) || cnt_v[i] == $past(cnt_v[i]) - CW'(1)));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_o     (irq_o),
  .ist_q     (ist_q),
  .ien_q     (ien_q),
  .run_v     (run_v),
  .expire_v  (expire_v),
  .wr_ctrl_v (wr_ctrl_v),
  .cnt_v     (cnt_v)
);

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int NCH = 2;
  localparam int CW  = 32;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          irq;

  always #10 clk = ~clk;

  tmr_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u_tmr_bank (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic logic [AW-1:0] a_ctrl(int c); return AW'(16 + 16 * c); endfunction
  function automatic logic [AW-1:0] a_intv(int c); return AW'(20 + 16 * c); endfunction
  function automatic logic [AW-1:0] a_cnt(int c);  return AW'(24 + 16 * c); endfunction
  localparam logic [AW-1:0] A_IEN = 8'h00;
  localparam logic [AW-1:0] A_IST = 8'h04;

  // reference model state
  logic [31:0]    m_intv [NCH];
  logic [31:0]    m_cnt  [NCH];
  logic [7:0]     m_ctrl [NCH];
  bit             m_run  [NCH];
  int             m_stop [NCH];
  int             m_pc   [NCH];
  logic [NCH-1:0] m_ien, m_ist, m_exp;
  logic [31:0]    m_rd, rd_n, o_cnt;
  logic [7:0]     o_ctrl;
  bit             m_irq, irq_n, o_run, stp;
  int             o_stop, thr;

  int    vecs = 0, errs = 0, cyc = 0, tick_per = 0;
  bit    started = 0, done = 0;
  string cur_req = "R1";

  function automatic logic [31:0] mread(logic [AW-1:0] a);
    logic [31:0] r = '0;
    if (a == A_IEN) r = 32'(m_ien);
    if (a == A_IST) r = 32'(m_ist);
    for (int c = 0; c < NCH; c++) begin
      if (a == a_ctrl(c)) r = 32'(m_ctrl[c]);
      if (a == a_intv(c)) r = m_intv[c];
      if (a == a_cnt(c))  r = m_cnt[c];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_intv[c] = '0; m_cnt[c] = '0; m_ctrl[c] = '0;
        m_run[c] = 0; m_stop[c] = 0; m_pc[c] = 0;
      end
      m_ien = '0; m_ist = '0; m_rd = '0; m_irq = 0;
    end else begin
      rd_n  = mread(addr);
      irq_n = |(m_ist & m_ien);
      m_exp = '0;
      for (int c = 0; c < NCH; c++) begin
        o_cnt = m_cnt[c]; o_ctrl = m_ctrl[c]; o_run = m_run[c]; o_stop = m_stop[c];
        stp = 0;
        if (tick && o_run) begin
          thr = (1 << o_ctrl[6:4]) - 1;
          if (m_pc[c] >= thr) begin m_pc[c] = 0; stp = 1; end
          else m_pc[c] = m_pc[c] + 1;
        end
        if (tick && o_stop != 0) begin
          m_stop[c] = o_stop - 1;
          if (o_stop == 1) m_run[c] = 0;
        end
        if (stp) begin
          if (o_cnt == 1) begin
            m_exp[c] = 1'b1;
            if (o_ctrl[7]) begin
              m_cnt[c] = 0; m_run[c] = 0; m_ctrl[c][0] = 1'b0; m_stop[c] = 0;
            end else m_cnt[c] = m_intv[c];
          end else if (o_cnt == 0) begin
            if (!o_ctrl[7]) m_cnt[c] = m_intv[c];
          end else m_cnt[c] = o_cnt - 1;
        end
        if (we && addr == a_intv(c)) m_intv[c] = wdata;
        if (we && addr == a_ctrl(c)) begin
          m_ctrl[c] = wdata[7:0] & 8'hFD;
          if (wdata[0] && wdata[1]) begin
            m_cnt[c] = m_intv[c]; m_run[c] = 1; m_stop[c] = 0; m_pc[c] = 0;
          end else if (wdata[0]) begin
            m_run[c] = 1; m_stop[c] = 0;
          end else if (o_run && o_stop == 0) begin
            m_stop[c] = 2;
          end
        end
      end
      if (we && addr == A_IST) m_ist = (m_ist & ~wdata[NCH-1:0]) | m_exp;
      else                     m_ist = m_ist | m_exp;
      if (we && addr == A_IEN) m_ien = wdata[NCH-1:0];
      m_rd  = rd_n;
      m_irq = irq_n;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      vecs++;
      if (rdata !== m_rd) begin
        errs++;
        $display("FAIL %s rdata: got %h expected %h (t=%0t)", cur_req, rdata, m_rd, $time);
      end
      vecs++;
      if (irq !== m_irq) begin
        errs++;
        $display("FAIL %s irq: got %b expected %b (t=%0t)", cur_req, irq, m_irq, $time);
      end
    end
  end

  always @(negedge clk) begin
    tick = (tick_per != 0) && (cyc % tick_per == 0);
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errs++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [CW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, int n);
    @(negedge clk); we = 1'b0; addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [CW-1:0] got, logic [CW-1:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s explicit: got %h expected %h", req, got, exp);
    end
  endtask

  logic [CW-1:0] s1, s2;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 64; a += 4) rd(AW'(a), 1);
    rd(A_IEN, 2);
    check("R1", rdata, 32'h0);

    // R2 / R12: map, readback, source tag, count writes ignored
    cur_req = "R2";
    wr(a_intv(0), 32'd5);
    wr(a_ctrl(0), 32'h0000_004E);
    rd(a_ctrl(0), 2);
    check("R3", rdata, 32'h0000_004C);
    rd(a_intv(0), 2);
    check("R2", rdata, 32'd5);
    cur_req = "R12";
    wr(a_cnt(0), 32'h1234);
    rd(a_cnt(0), 2);
    check("R12", rdata, 32'h0);

    // R3 / R4 / R5: load and periodic counting
    cur_req = "R3";
    tick_per = 1;
    wr(A_IEN, 32'h1);
    wr(a_ctrl(0), 32'h0000_000F);
    cur_req = "R4";
    rd(a_cnt(0), 4);
    cur_req = "R5";
    rd(a_cnt(0), 20);
    rd(A_IST, 2);
    check("R4", rdata, 32'h1);

    // R9: write-one-to-clear
    cur_req = "R9";
    wr(A_IST, 32'h0);
    rd(A_IST, 2);
    wr(A_IST, 32'h1);
    rd(A_IST, 8);

    // R10: enable gating
    cur_req = "R10";
    wr(A_IEN, 32'h0);
    rd(A_IST, 12);
    check("R10", 32'(irq), 32'h0);
    wr(A_IEN, 32'h1);
    rd(A_IST, 4);

    // R8: delayed stop then resume
    cur_req = "R8";
    tick_per = 3;
    wr(a_intv(0), 32'd40);
    wr(a_ctrl(0), 32'h03);
    rd(a_cnt(0), 6);
    wr(a_ctrl(0), 32'h00);
    rd(a_cnt(0), 20);
    wr(a_ctrl(0), 32'h01);
    rd(a_cnt(0), 10);
    wr(a_ctrl(0), 32'h00);
    rd(a_cnt(0), 12);

    // R6: one-shot on channel 1
    cur_req = "R6";
    tick_per = 1;
    wr(A_IEN, 32'h3);
    wr(a_intv(1), 32'd4);
    wr(a_ctrl(1), 32'h83);
    rd(a_cnt(1), 10);
    rd(a_ctrl(1), 2);
    check("R6", rdata, 32'h80);
    rd(a_cnt(1), 2);
    check("R6", rdata, 32'h0);
    wr(A_IST, 32'h3);

    // R7: prescaler codes
    cur_req = "R7";
    wr(a_intv(1), 32'd3);
    wr(a_ctrl(1), 32'h23);
    rd(a_cnt(1), 30);
    tick_per = 2;
    rd(a_cnt(1), 20);
    wr(a_ctrl(1), 32'h73);
    rd(a_cnt(1), 300);
    tick_per = 0;
    rd(a_cnt(1), 10);

    // R11: free-running all-ones interval
    cur_req = "R11";
    tick_per = 1;
    wr(a_intv(0), 32'hFFFF_FFFF);
    wr(a_ctrl(0), 32'h03);
    rd(a_cnt(0), 3);
    s1 = rdata;
    rd(a_cnt(0), 5);
    s2 = rdata;
    check("R11", 32'((~s2) > (~s1)), 32'h1);

    // R1: reset again mid-run
    cur_req = "R1";
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(a_cnt(0), 3);
    check("R1", rdata, 32'h0);
    finish_run();
  end
endmodule